// File: doc/BRIEF.md
# Carry-Save Array Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. Every partial-product row is formed at once by an AND plane: row j holds the multiplicand gated by multiplier bit j and is weighted by 2^j. The rows are then folded one at a time by a chain of 3:2 carry-save stages. Each stage keeps its sum vector and its carry vector apart and does not ripple carries along the row. A single ripple adder at the end merges the last sum/carry pair into the product.

The operand width is a parameter. An output register is included by default so that the long combinational path ends in a flop. When the register is removed, the product follows the operands combinationally. The register clears to zero under a synchronous active-high reset.

Top module: `csa_array_mult`

## Requirements
- R1: For every pair of unsigned operands, the product output equals a_in × b_in, taken over the full 2N bits.
- R2: With the output register enabled (the default), prod_out shows the product of the operands sampled at the previous rising clock edge. An operand change between edges does not reach prod_out until the next rising edge.
- R3: When rst is high at a rising clock edge, prod_out becomes 0 at that edge, whatever the operand values are.
- R4: When either operand is zero, the product is zero.
- R5: All-ones operands give (2^N−1)², which is 0xFE01 for N=8, with no wraparound.
- R6: For each carry-save stage, its sum vector plus its carry vector equals the sum of its three input vectors, modulo 2^(2N).
- R7: No carry is lost. No carry-save stage generates a carry out of bit 2N−1, and the final ripple adder produces no carry out.
- R8: Multiplying by 2^k gives the multiplicand shifted left by k bits.
- R9: Swapping the two operands leaves the product unchanged.
- R10: A 4-bit carry-save stage fed 0011, 0010 and 0000 yields sum 0001 and carry 0100, with the carry already moved up one bit. A second stage fed 0001, 0100 and 0011 yields sum 0110 and carry 0010, and those two vectors add to 1000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_in | input | N | Unsigned multiplicand |
| b_in | input | N | Unsigned multiplier |
| prod_out | output | 2N | Unsigned product, registered by default |

## Verification
The embedded assertions check four things on every clock edge:
- the registered product against a behavioural multiply of the previous operands;
- that a zero operand gives a zero result;
- that every carry-save stage conserves the value of its three inputs;
- that neither a stage nor the final adder pushes a carry past the top bit.

The bench's scenarios cover the remaining behaviour. Reset clearing the output while the operands are nonzero is one. One-cycle latency, seen by sampling just after an operand change, is another. The bench also covers the all-ones corner, power-of-two shifts, operand swapping and the worked 4-bit carry-save example on standalone stages. For the default width it sweeps every operand pair and then adds seeded random pairs.

// File: rtl/csa_mult_pkg.sv
package csa_mult_pkg;

    localparam int MIN_WIDTH = 2;

    typedef struct packed {
        logic sum;
        logic cy;
    } bit_pair_t;

    // 3:2 compression of one bit column
    function automatic bit_pair_t fa3(input logic x, input logic y, input logic z);
        bit_pair_t r;
        r.sum = x ^ y ^ z;
        r.cy  = (x & y) | (x & z) | (y & z);
        return r;
    endfunction

endpackage

// File: rtl/pp_gen.sv
module pp_gen
    import csa_mult_pkg::*;
#(
    parameter int N  = 8,
    parameter int PW = 2 * N
) (
    input  logic [N-1:0]           mcand,
    input  logic [N-1:0]           mplier,
    output logic [N-1:0][PW-1:0]   rows
);
    // Row j: multiplicand gated by multiplier bit j, weighted by 2^j
    for (genvar j = 0; j < N; j++) begin : g_row
        logic [PW-1:0] gated;
        assign gated   = {{(PW-N){1'b0}}, mcand & {N{mplier[j]}}};
        assign rows[j] = gated << j;
    end
endmodule

// File: rtl/csa_row.sv
module csa_row
    import csa_mult_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o,
    output logic         drop_o
);
    logic [W-1:0] raw_cy;

    for (genvar i = 0; i < W; i++) begin : g_col
        bit_pair_t bp;
        assign bp        = fa3(in_a[i], in_b[i], in_c[i]);
        assign sum_o[i]  = bp.sum;
        assign raw_cy[i] = bp.cy;
    end

    // Carries are saved, moved up one column for the next stage
    assign carry_o = {raw_cy[W-2:0], 1'b0};
    assign drop_o  = raw_cy[W-1];
endmodule

// File: rtl/cpa.sv
module cpa
    import csa_mult_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s,
    output logic         cout
);
    logic [W:0] c;
    assign c[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        bit_pair_t bp;
        assign bp     = fa3(x[i], y[i], c[i]);
        assign s[i]   = bp.sum;
        assign c[i+1] = bp.cy;
    end

    assign cout = c[W];
endmodule

// File: rtl/csa_array_mult.sv
module csa_array_mult
    import csa_mult_pkg::*;
#(
    parameter int N       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     a_in,
    input  logic [N-1:0]     b_in,
    output logic [2*N-1:0]   prod_out
);
    localparam int PW   = 2 * N;
    localparam int LAST = N - 2;

    if (N < MIN_WIDTH) begin : g_bad_width
        $error("csa_array_mult: N must be at least 2");
    end

    logic [N-1:0][PW-1:0]  pp;
    logic [LAST:0][PW-1:0] sv;
    logic [LAST:0][PW-1:0] cv;
    logic [PW-1:0]         comb_prod;
    logic                  final_cout;

    pp_gen #(.N(N), .PW(PW)) u_pp (
        .mcand  (a_in),
        .mplier (b_in),
        .rows   (pp)
    );

    // Seed the reduction with the two lowest rows
    assign sv[0] = pp[0];
    assign cv[0] = pp[1];

    for (genvar k = 1; k <= LAST; k++) begin : g_stage
        logic drop;
        csa_row #(.W(PW)) u_csa (
            .in_a    (sv[k-1]),
            .in_b    (cv[k-1]),
            .in_c    (pp[k+1]),
            .sum_o   (sv[k]),
            .carry_o (cv[k]),
            .drop_o  (drop)
        );

        AST_CSA_CONSERVE: assert property (@(posedge clk) disable iff (rst)
            (sv[k] + cv[k]) == (sv[k-1] + cv[k-1] + pp[k+1]));      // R6
        AST_CSA_NO_DROP: assert property (@(posedge clk) disable iff (rst)
            drop == 1'b0);                                          // R7
    end

    cpa #(.W(PW)) u_cpa (
        .x    (sv[LAST]),
        .y    (cv[LAST]),
        .s    (comb_prod),
        .cout (final_cout)
    );

    AST_CPA_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        final_cout == 1'b0);                                        // R7

    if (REG_OUT) begin : g_reg
        logic [PW-1:0] prod_q;
        always_ff @(posedge clk) begin
            if (rst) prod_q <= '0;
            else     prod_q <= comb_prod;
        end
        assign prod_out = prod_q;

        AST_PROD_MATCH: assert property (@(posedge clk) disable iff (rst)
            !rst |=> prod_out == (PW'($past(a_in)) * PW'($past(b_in))));  // R2
        AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
            (a_in == '0 || b_in == '0) |=> prod_out == '0);              // R4
    end else begin : g_comb
        assign prod_out = comb_prod;

        AST_PROD_MATCH: assert property (@(posedge clk) disable iff (rst)
            prod_out == (PW'(a_in) * PW'(b_in)));                        // R1
        AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
            (a_in == '0 || b_in == '0) |-> prod_out == '0);              // R4
    end
endmodule

// File: tb/tb_csa_array_mult.sv
`timescale 1ns/1ps
module tb_csa_array_mult;
    localparam int N  = 8;
    localparam int PW = 2 * N;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  a_in;
    logic [N-1:0]  b_in;
    logic [PW-1:0] prod_out;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    csa_array_mult #(.N(N), .REG_OUT(1'b1)) dut (
        .clk      (clk),
        .rst      (rst),
        .a_in     (a_in),
        .b_in     (b_in),
        .prod_out (prod_out)
    );

    // Standalone stages for the worked 4-bit example (R10)
    logic [3:0] s1, c1, s2, c2;
    logic       d1, d2;
    csa_row #(.W(4)) u_ws1 (.in_a(4'b0011), .in_b(4'b0010), .in_c(4'b0000),
                            .sum_o(s1), .carry_o(c1), .drop_o(d1));
    csa_row #(.W(4)) u_ws2 (.in_a(s1), .in_b(c1), .in_c(4'b0011),
                            .sum_o(s2), .carry_o(c2), .drop_o(d2));

    function automatic logic [PW-1:0] ref_mul(input logic [N-1:0] x, input logic [N-1:0] y);
        return PW'(x) * PW'(y);
    endfunction

    task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, check at the next falling edge (one rising edge between)
    task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y, input string req);
        a_in = x;
        b_in = y;
        @(negedge clk);
        check(req, prod_out, ref_mul(x, y));
    endtask

    initial begin
        logic [PW-1:0] p_ab;
        logic [PW-1:0] p_ba;
        rst  = 1'b1;
        a_in = 8'hFF;
        b_in = 8'hFF;
        repeat (3) @(negedge clk);
        check("R3 reset clears output", prod_out, '0);
        rst = 1'b0;

        // R10 worked carry-save example
        #1;
        check("R10 stage1 sum",   PW'(s1), PW'(4'b0001));
        check("R10 stage1 carry", PW'(c1), PW'(4'b0100));
        check("R10 stage2 sum",   PW'(s2), PW'(4'b0110));
        check("R10 stage2 carry", PW'(c2), PW'(4'b0010));
        check("R10 final add",    PW'(s2 + c2), PW'(4'b1000));
        check("R10 no drop",      PW'({d1, d2}), '0);
        @(negedge clk);

        apply(8'h00, 8'h5A, "R4 zero multiplicand");
        apply(8'hA5, 8'h00, "R4 zero multiplier");
        apply(8'hFF, 8'hFF, "R5 all ones");
        check("R5 all ones value", prod_out, 16'hFE01);
        apply(8'h37, 8'h10, "R8 power of two");
        check("R8 shift value", prod_out, 16'h0370);
        apply(8'h01, 8'hC3, "R1 unit multiplicand");

        // R9 commutativity
        apply(8'h3C, 8'hC5, "R9 forward");
        p_ab = prod_out;
        apply(8'hC5, 8'h3C, "R9 swapped");
        p_ba = prod_out;
        check("R9 forward equals swapped", p_ba, p_ab);

        // R2 latency: new operands not visible before the next rising edge
        a_in = 8'h12;
        b_in = 8'h34;
        #1;
        check("R2 output holds until edge", prod_out, ref_mul(8'hC5, 8'h3C));
        @(negedge clk);
        check("R2 output after edge", prod_out, ref_mul(8'h12, 8'h34));

        // R3 reset in mid-run with nonzero operands
        a_in = 8'hE7;
        b_in = 8'h9B;
        rst  = 1'b1;
        @(negedge clk);
        check("R3 mid-run reset", prod_out, '0);
        rst = 1'b0;
        @(negedge clk);

        // Exhaustive sweep (R1, R6, R7 stage behaviour)
        for (int i = 0; i < (1 << (2 * N)); i++) begin
            apply(N'(i), N'(i >> N), "R1/R6/R7 exhaustive");
        end

        // Seeded random
        void'($urandom(32'd20240611));
        for (int i = 0; i < 500; i++) begin
            apply(N'($urandom), N'($urandom), "R1 random");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule